// File: doc/BRIEF.md
# Tri-State PWM Gate Driver Controller

This block is the digital control core of a synchronous buck power stage. A comparator front end reduces the PWM pin to one of three levels: high, low, or stuck between the two thresholds. The block turns that level into complementary high-side and low-side gate enables. It keeps a non-overlap gap between them and shuts both gates off when the PWM line sits in the middle window too long.

Several conditions hold both gates low. The block is held off by an active-low driver enable, an undervoltage-lockout level that is already filtered, and a supply-good flag. An active-low low-side disable keeps the synchronous rectifier off so the converter can run in discontinuous conduction, while the high-side gate still follows PWM. A mode output reports whether the stage is shut down, latched in tri-state, or switching.

The tri-state latch is set from reset. The stage therefore stays idle after power-up until the first clean high PWM level arrives.

Top module: `tspwm_gate_ctrl`

## Requirements
- R1: With the stage active and the PWM code steady, code 2'b10 (high) gives `hs_gate`=1, `ls_gate`=0, and code 2'b00 (low) gives `hs_gate`=0, `ls_gate`=1. A middle code (2'b01 or 2'b11) held for fewer than HOLD_CYC cycles keeps the last high/low decision.
- R2: A middle code held for HOLD_CYC consecutive clock edges sets the tri-state latch. Both gates then go low and `mode` becomes 1 after that edge. Any high or low code before then restarts the count.
- R3: Once latched in tri-state, a low code leaves both gates low and `mode` at 1. Only a high code clears the latch.
- R4: After reset the block is in tri-state (`mode`=1, both gates low). It stays there under a low PWM code until a high code is seen.
- R5: `drv_on_n`=0 forces both gates low and `mode`=0 in the same clock cycle, with no dead-time wait.
- R6: `ls_off_n`=0 keeps `ls_gate` low while `hs_gate` still follows PWM. With `ls_off_n`=1 both gates follow PWM.
- R7: `uvlo`=1 or `sup_ok`=0 forces both gates low and `mode`=0 in the same clock cycle.
- R8: `hs_gate` and `ls_gate` are never both 1. When one gate turns off, the other turns on only after exactly DEAD_CYC+1 clock cycles in which both are low.
- R9: `mode` encodes 0 = shutdown, 1 = tri-state, 2 = active. Shutdown has priority over tri-state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 2 | Digitized PWM: 00 low, 10 high, 01/11 middle window |
| drv_on_n | input | 1 | Active-low driver enable polarity: 1 allows switching, 0 disables |
| ls_off_n | input | 1 | 0 holds the low-side gate off |
| uvlo | input | 1 | Filtered undervoltage lockout, 1 = locked out |
| sup_ok | input | 1 | Logic supply good |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| mode | output | 2 | 0 shutdown, 1 tri-state, 2 active |

## Verification
The bench builds the block with HOLD_CYC=6 and DEAD_CYC=2. These short values bring a number of boundary cases within a few cycles of stimulus:
- the edge just before the tri-state timeout and the edge that trips it;
- a count restart caused by one low cycle;
- the full three-cycle non-overlap gap.

Steady-state vectors are held for 20 cycles, which is longer than either window. This lets every mode, gate-disable and re-arm combination settle before it is compared.

// File: rtl/tspwm_gate_ctrl.sv
module tspwm_gate_ctrl #(
  parameter int HOLD_CYC = 10,
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic       drv_on_n,
  input  logic       ls_off_n,
  input  logic       uvlo,
  input  logic       sup_ok,
  output logic       hs_gate,
  output logic       ls_gate,
  output logic [1:0] mode
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [1:0] M_SHUT = 2'd0, M_TRI = 2'd1, M_ACT = 2'd2;

  logic [CW-1:0] mid_cnt;
  logic [DW-1:0] dt_cnt;
  logic          tri_q, hi_q, hs_q, ls_q;

  wire is_hi   = (pwm_lvl == 2'b10);
  wire is_lo   = (pwm_lvl == 2'b00);
  wire is_mid  = !is_hi && !is_lo;
  wire inhibit = !drv_on_n || uvlo || !sup_ok;
  wire trip    = is_mid && (mid_cnt == CW'(HOLD_CYC - 1));
  wire active  = !inhibit && !tri_q;
  wire cur_hi  = is_hi ? 1'b1 : (is_lo ? 1'b0 : hi_q);
  wire want_hs = active && cur_hi;
  wire want_ls = active && !cur_hi && ls_off_n;
  wire gap_ok  = !hs_q && !ls_q && (dt_cnt == DW'(DEAD_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_cnt <= '0;
      tri_q   <= 1'b1;
      hi_q    <= 1'b0;
    end else begin
      if (!is_mid)                        mid_cnt <= '0;
      else if (mid_cnt != CW'(HOLD_CYC - 1)) mid_cnt <= mid_cnt + 1'b1;
      if (is_hi)      tri_q <= 1'b0;
      else if (trip)  tri_q <= 1'b1;
      if (is_hi)      hi_q <= 1'b1;
      else if (is_lo) hi_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      dt_cnt <= '0;
    end else begin
      if (!want_hs || trip)  hs_q <= 1'b0;
      else if (gap_ok)       hs_q <= 1'b1;
      if (!want_ls || trip)  ls_q <= 1'b0;
      else if (gap_ok)       ls_q <= 1'b1;
      if (hs_q || ls_q)                  dt_cnt <= '0;
      else if (dt_cnt != DW'(DEAD_CYC))  dt_cnt <= dt_cnt + 1'b1;
    end
  end

  assign hs_gate = hs_q && active;
  assign ls_gate = ls_q && active && ls_off_n;
  assign mode    = inhibit ? M_SHUT : (tri_q ? M_TRI : M_ACT);

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));
  a_r8_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> !$past(ls_q));
  a_r8_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> !$past(hs_q));
  a_r5_disable_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_on_n |-> (!hs_gate && !ls_gate && mode == M_SHUT));
  a_r7_supply_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo || !sup_ok) |-> (!hs_gate && !ls_gate));
  a_r3_tri_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_q && !is_hi) |=> tri_q);
  a_r6_ls_held_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_off_n |=> !ls_q);
endmodule

// File: tb/tspwm_gate_ctrl_bench.sv
module tspwm_gate_ctrl_bench;
  localparam int CLK_PER = 10;
  localparam int HOLD = 6;
  localparam int DEAD = 2;
  localparam int NV = 12;
  // {pwm[1:0], drv_on_n, ls_off_n, uvlo, sup_ok, hs, ls, mode[1:0]}
  localparam logic [9:0] VEC [NV] = '{
    10'b10_1_1_0_1_1_0_10,
    10'b00_1_1_0_1_0_1_10,
    10'b01_1_1_0_1_0_0_01,
    10'b00_1_1_0_1_0_0_01,
    10'b10_1_1_0_1_1_0_10,
    10'b00_1_0_0_1_0_0_10,
    10'b10_1_0_0_1_1_0_10,
    10'b10_0_1_0_1_0_0_00,
    10'b00_1_1_0_1_0_1_10,
    10'b00_1_1_1_1_0_0_00,
    10'b10_1_1_0_0_0_0_00,
    10'b10_1_1_0_1_1_0_10
  };
  localparam string VREQ [NV] = '{"R1", "R1", "R2", "R3", "R3", "R6",
                                 "R6", "R5", "R1", "R7", "R7", "R9"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pwm_lvl = 2'b00;
  logic drv_on_n = 1'b1, ls_off_n = 1'b1, uvlo = 1'b0, sup_ok = 1'b1;
  logic hs_gate, ls_gate;
  logic [1:0] mode;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  tspwm_gate_ctrl #(.HOLD_CYC(HOLD), .DEAD_CYC(DEAD)) u_tspwm_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .drv_on_n(drv_on_n),
    .ls_off_n(ls_off_n), .uvlo(uvlo), .sup_ok(sup_ok),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .mode(mode));

  task automatic check(input string req, input logic [3:0] exp);
    n_chk++;
    if ({hs_gate, ls_gate, mode} !== exp) begin
      n_fail++;
      $display("FAIL %s: {hs,ls,mode} actual %b expected %b at %0t",
               req, {hs_gate, ls_gate, mode}, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    check("R4", 4'b00_01);          // reset: tri-state, gates low
    rst_n = 1'b1;
    step(10);
    check("R4", 4'b00_01);          // low PWM does not arm after power-up

    for (int i = 0; i < NV; i++) begin
      {pwm_lvl, drv_on_n, ls_off_n, uvlo, sup_ok} = VEC[i][9:4];
      step(20);
      check(VREQ[i], VEC[i][3:0]);
    end

    // R2 boundary: HOLD-1 middle edges keep last decision, the HOLD-th trips
    pwm_lvl = 2'b01;
    step(HOLD - 1);
    check("R2", 4'b10_10);
    step(1);
    check("R2", 4'b00_01);

    // R2 restart: one low cycle resets the count
    pwm_lvl = 2'b10; step(10);
    check("R3", 4'b10_10);
    pwm_lvl = 2'b11; step(HOLD - 1);
    pwm_lvl = 2'b00; step(1);
    pwm_lvl = 2'b01; step(HOLD - 1);
    check("R2", {2'b00, 2'b10} | {hs_gate, ls_gate, 2'b00});
    step(1);
    check("R2", 4'b00_01);

    // R8 dead time: high -> low gives DEAD+1 cycles with both low
    pwm_lvl = 2'b10; step(10);
    check("R8", 4'b10_10);
    pwm_lvl = 2'b00;
    for (int k = 0; k < DEAD + 1; k++) begin
      step(1);
      check("R8", 4'b00_10);
    end
    step(1);
    check("R8", 4'b01_10);
    // R8 dead time: low -> high
    pwm_lvl = 2'b10;
    for (int k = 0; k < DEAD + 1; k++) begin
      step(1);
      check("R8", 4'b00_10);
    end
    step(1);
    check("R8", 4'b10_10);

    // R5: disable acts within the same cycle
    drv_on_n = 1'b0;
    #1;
    check("R5", 4'b00_00);
    drv_on_n = 1'b1;
    step(10);
    // R7: lockout acts within the same cycle
    uvlo = 1'b1;
    #1;
    check("R7", 4'b00_00);
    uvlo = 1'b0;
    step(10);
    check("R9", 4'b10_10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule